// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status and Control Flags

This unit adds, subtracts and applies bitwise AND, OR and XOR to two operands, working either on the full 16-bit word or on the low 8 bits only. Every accepted operation stores its result and updates a 16-bit flag word in one clock cycle. Add-with-carry and subtract-with-borrow take an external carry input. Subtraction computes A minus B minus the borrow-in, and the carry flag then means that a borrow happened.

Besides the result-derived status flags (carry, parity, auxiliary carry, zero, sign, overflow), the flag word holds three control bits: single step, interrupt enable and direction. Only dedicated set and clear commands change them, and those commands leave the result and the status flags alone. Parity looks at the low byte of the result only, whatever the width. The auxiliary carry records a carry out of bit 3, or a borrow into it.

Top module: `status_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `flags` become zero.
- R2: Opcodes 0 (add) and 1 (add plus `carry_in`) give the sum truncated to the selected width, and flag bit 0 (carry) is set when the sum does not fit in that width.
- R3: Opcodes 2 (subtract) and 3 (subtract with `carry_in` as borrow) give A-B-borrow truncated to the width, and flag bit 0 is set when a borrow out of the top bit occurred.
- R4: Flag bit 11 (overflow) is set after an add or subtract when the signed result at the selected width lies outside that width's signed range.
- R5: Flag bit 7 (sign) equals the top bit of the result at the selected width, and flag bit 6 (zero) is set when the result at that width is all zeros.
- R6: Flag bit 4 (auxiliary carry) is set after an add when bits 3..0 produce a carry into bit 4, and after a subtract when they need a borrow.
- R7: Flag bit 2 (parity) is set when result bits 7..0 hold an even number of ones, in both the 8-bit and 16-bit modes.
- R8: Opcodes 4 (AND), 5 (OR) and 6 (XOR) clear flag bits 0, 4 and 11 and update bits 2, 6 and 7.
- R9: Opcodes 8/9 clear/set flag bit 8 (single step), 10/11 clear/set bit 9 (interrupt enable), and 12/13 clear/set bit 10 (direction). Arithmetic and logic operations never change bits 8 to 10, and these commands change neither `result` nor any other flag.
- R10: With `wr_en` low, or with opcode 7, 14 or 15, `result` and `flags` keep their values.
- R11: Flag bits 1, 3, 5 and 12 to 15 always read zero, and in 8-bit mode (`wide` = 0) `result` bits 15..8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Accept the operation on this edge |
| op | input | 4 | Operation / flag command code |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| carry_in | input | 1 | Carry for opcode 1, borrow for opcode 3 |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word |

## Verification
The assertions assume that `wr_en`, `op` and `wide` are stable and known at every clock edge after reset. They also assume that only the listed opcodes change state, so the checks on held values can use `wr_en` and the opcode class alone. The stimulus changes inputs only on falling edges. It mixes every defined opcode with the undefined codes 7, 14 and 15, and in 8-bit mode it puts nonzero data in the upper operand bits so that width masking is exercised.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W = 16;

  localparam int FB_CY   = 0;
  localparam int FB_PAR  = 2;
  localparam int FB_AUX  = 4;
  localparam int FB_ZERO = 6;
  localparam int FB_SIGN = 7;
  localparam int FB_STEP = 8;
  localparam int FB_IRQ  = 9;
  localparam int FB_DIR  = 10;
  localparam int FB_OVF  = 11;

  localparam logic [FLAG_W-1:0] CTL_MASK  = 16'h0700;
  localparam logic [FLAG_W-1:0] USED_MASK = 16'h0FD5;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_ADC      = 4'd1,
    OP_SUB      = 4'd2,
    OP_SBB      = 4'd3,
    OP_AND      = 4'd4,
    OP_OR       = 4'd5,
    OP_XOR      = 4'd6,
    OP_NONE     = 4'd7,
    OP_CLR_STEP = 4'd8,
    OP_SET_STEP = 4'd9,
    OP_CLR_IRQ  = 4'd10,
    OP_SET_IRQ  = 4'd11,
    OP_CLR_DIR  = 4'd12,
    OP_SET_DIR  = 4'd13
  } alu_op_e;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              wide,
  input  alu_op_e           op,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cy,
  output logic              aux,
  output logic              ovf
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mask, am, bm;
  logic [DATA_W:0]   ext;
  logic              ci, is_add, is_sub, sa, sb, sr;

  always_comb begin
    mask   = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    am     = a & mask;
    bm     = b & mask;
    is_add = (op == OP_ADD) || (op == OP_ADC);
    is_sub = (op == OP_SUB) || (op == OP_SBB);
    ci     = ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: ext = {1'b0, am} + {1'b0, bm} + (DATA_W+1)'(ci);
      OP_SUB, OP_SBB: ext = {1'b0, am} - {1'b0, bm} - (DATA_W+1)'(ci);
      OP_AND:         ext = {1'b0, am & bm};
      OP_OR:          ext = {1'b0, am | bm};
      OP_XOR:         ext = {1'b0, am ^ bm};
      default:        ext = '0;
    endcase
    res = ext[DATA_W-1:0] & mask;
    sa  = wide ? am[DATA_W-1] : am[HALF_W-1];
    sb  = wide ? bm[DATA_W-1] : bm[HALF_W-1];
    sr  = wide ? res[DATA_W-1] : res[HALF_W-1];
    cy  = (is_add || is_sub) && (wide ? ext[DATA_W] : ext[HALF_W]);
    // nibble carry/borrow shows up as a flip of bit 4 against the operands
    aux = (is_add || is_sub) && (am[4] ^ bm[4] ^ ext[4]);
    ovf = (is_add && (sa == sb) && (sr != sa)) ||
          (is_sub && (sa != sb) && (sr != sa));
  end
endmodule

// File: rtl/flag_pack.sv
module flag_pack
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic              wide,
  input  logic              cy,
  input  logic              aux,
  input  logic              ovf,
  output logic [FLAG_W-1:0] status
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    status          = '0;
    status[FB_CY]   = cy;
    status[FB_PAR]  = ~^res[7:0];
    status[FB_AUX]  = aux;
    status[FB_ZERO] = wide ? (res == '0) : (res[HALF_W-1:0] == '0);
    status[FB_SIGN] = wide ? res[DATA_W-1] : res[HALF_W-1];
    status[FB_OVF]  = ovf;
  end
endmodule

// File: rtl/status_alu.sv
module status_alu
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        op,
  input  logic              wide,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op_e;
  logic [DATA_W-1:0] dp_res;
  logic              dp_cy, dp_aux, dp_ovf;
  logic [FLAG_W-1:0] status_new;
  logic              is_alu, is_logic, is_ctl;
  logic [1:0]        ctl_sel;
  logic [DATA_W-1:0] result_q;
  logic [FLAG_W-1:0] flags_q;

  assign op_e     = alu_op_e'(op);
  assign is_alu   = (op[3] == 1'b0) && (op != 4'd7);
  assign is_logic = (op == 4'd4) || (op == 4'd5) || (op == 4'd6);
  assign is_ctl   = op[3] && (op[2:1] != 2'b11);
  assign ctl_sel  = op[2:1];

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .a(a), .b(b), .wide(wide), .op(op_e), .cin(carry_in),
    .res(dp_res), .cy(dp_cy), .aux(dp_aux), .ovf(dp_ovf)
  );

  flag_pack #(.DATA_W(DATA_W)) u_fp (
    .res(dp_res), .wide(wide), .cy(dp_cy), .aux(dp_aux), .ovf(dp_ovf),
    .status(status_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (wr_en) begin
      if (is_alu) begin
        result_q <= dp_res;
        flags_q  <= status_new | (flags_q & CTL_MASK);
      end else if (is_ctl) begin
        case (ctl_sel)
          2'd0:    flags_q[FB_STEP] <= op[0];
          2'd1:    flags_q[FB_IRQ]  <= op[0];
          default: flags_q[FB_DIR]  <= op[0];
        endcase
      end
    end
  end

  assign result = result_q;
  assign flags  = flags_q;

  // R10: no accepted operation, nothing moves
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(result_q) && $stable(flags_q)));

  // R11: reserved flag bits stay clear
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~USED_MASK) == '0);

  // R11: narrow results have a clear upper half
  p_narrow_hi_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_alu && !wide) |=> (result_q[DATA_W-1:HALF_W] == '0));

  // R9: arithmetic and logic leave the control bits alone
  p_ctl_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_alu) |=> $stable(flags_q & CTL_MASK));

  // R9: control commands leave the result alone
  p_ctl_result_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_ctl) |=> $stable(result_q));

  // R8: logic ops clear carry, aux and overflow
  p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_logic) |=> (!flags_q[FB_CY] && !flags_q[FB_AUX] && !flags_q[FB_OVF]));
endmodule

// File: tb/status_alu_bench.sv
module status_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        wide = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] a = 16'h0, b = 16'h0;
  logic [15:0] result, flags;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_res = 16'h0, m_flg = 16'h0;
  logic [15:0] q_res[$];
  logic [15:0] q_flg[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  status_alu u_status_alu (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op(op), .wide(wide),
    .carry_in(carry_in), .a(a), .b(b), .result(result), .flags(flags)
  );

  task automatic check(input string tag, input logic [15:0] r, input logic [15:0] f,
                       input logic [15:0] er, input logic [15:0] ef);
    tests++;
    if (r !== er || f !== ef) begin
      fails++;
      $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h", tag, r, f, er, ef);
    end
  endtask

  // monitor: one expected item per clock, compared away from the active edge
  always @(negedge clk) begin
    if (q_res.size() > 0) begin
      logic [15:0] er, ef;
      string t;
      er = q_res.pop_front();
      ef = q_flg.pop_front();
      t  = q_tag.pop_front();
      check(t, result, flags, er, ef);
    end
  end

  // reference model written from the requirements
  task automatic model(input int o, input bit w, input bit ci, input int av_in, input int bv_in, input bit we);
    int n, mk, hs, av, bv, sa, sb, s, ss, r, c;
    bit cf, af, of;
    n  = w ? 16 : 8;
    mk = (1 << n) - 1;
    hs = 1 << (n - 1);
    av = av_in & mk;
    bv = bv_in & mk;
    sa = (av >= hs) ? av - (1 << n) : av;
    sb = (bv >= hs) ? bv - (1 << n) : bv;
    if (!we) return;
    if (o <= 6) begin
      cf = 0; af = 0; of = 0; r = 0;
      if (o <= 3) begin
        c = (o == 1 || o == 3) ? int'(ci) : 0;
        if (o <= 1) begin
          s  = av + bv + c;
          cf = s > mk;
          af = ((av & 15) + (bv & 15) + c) > 15;
          ss = sa + sb + c;
        end else begin
          s  = av - bv - c;
          cf = s < 0;
          af = ((av & 15) - (bv & 15) - c) < 0;
          ss = sa - sb - c;
        end
        r  = s & mk;
        of = (ss >= hs) || (ss < -hs);
      end else if (o == 4) r = av & bv;
      else if (o == 5) r = av | bv;
      else r = av ^ bv;
      m_res = 16'(r);
      m_flg = m_flg & 16'h0700;
      m_flg[0]  = cf;
      m_flg[2]  = ($countones(r & 255) % 2) == 0;
      m_flg[4]  = af;
      m_flg[6]  = (r == 0);
      m_flg[7]  = ((r >> (n - 1)) & 1) == 1;
      m_flg[11] = of;
    end else if (o >= 8 && o <= 13) begin
      m_flg[8 + (o - 8) / 2] = (o % 2) == 1;
    end
  endtask

  task automatic drive(input string tag, input int o, input bit w, input bit ci,
                       input int av, input int bv, input bit we);
    @(negedge clk);
    op = 4'(o); wide = w; carry_in = ci; a = 16'(av); b = 16'(bv); wr_en = we;
    model(o, w, ci, av, bv, we);
    @(posedge clk);
    #1;
    q_res.push_back(m_res);
    q_flg.push_back(m_flg);
    q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: result=%h flags=%h expected result=%h flags=%h", result, flags, m_res, m_flg);
    finish_run();
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", result, flags, 16'h0, 16'h0);

    drive("R2 add 8b carry/zero", 0, 0, 0, 16'h00FF, 16'h0001, 1);
    drive("R4 add 8b overflow", 0, 0, 0, 16'h007F, 16'h0001, 1);
    drive("R6 add 16b nibble carry", 0, 1, 0, 16'h00FF, 16'h0001, 1);
    drive("R2 add 16b carry", 0, 1, 0, 16'hFFFF, 16'h0002, 1);
    drive("R2 adc with carry_in", 1, 1, 1, 16'h1234, 16'h0FFF, 1);
    drive("R3 sub 8b borrow", 2, 0, 0, 16'h0000, 16'h0001, 1);
    drive("R3 sbb with borrow_in", 3, 1, 1, 16'h5000, 16'h4FFF, 1);
    drive("R4 sub 8b overflow", 2, 0, 0, 16'h0080, 16'h0001, 1);
    drive("R4 sub 16b overflow", 2, 1, 0, 16'h8000, 16'h0001, 1);
    drive("R6 sub nibble borrow", 2, 1, 0, 16'h0010, 16'h0001, 1);
    drive("R5 sub equal gives zero", 2, 1, 0, 16'hABCD, 16'hABCD, 1);
    drive("R7 parity low byte 16b", 0, 1, 0, 16'h0300, 16'h0001, 1);
    drive("R11 narrow ignores upper bits", 0, 0, 0, 16'hFF10, 16'hAA20, 1);
    drive("R9 set step", 9, 0, 0, 0, 0, 1);
    drive("R9 set irq", 11, 0, 0, 0, 0, 1);
    drive("R9 set dir", 13, 0, 0, 0, 0, 1);
    drive("R2 add keeps control bits", 0, 1, 0, 16'h7FFF, 16'h7FFF, 1);
    drive("R8 and clears cy/aux/ovf", 4, 1, 0, 16'hF0F0, 16'h8FF0, 1);
    drive("R8 or", 5, 0, 0, 16'h0000, 16'h0000, 1);
    drive("R8 xor", 6, 0, 0, 16'h1281, 16'h3400, 1);
    drive("R9 clear irq", 10, 1, 0, 16'hFFFF, 16'hFFFF, 1);
    drive("R10 write disabled", 0, 1, 1, 16'h1111, 16'h2222, 0);
    drive("R10 opcode 7 no effect", 7, 1, 0, 16'h1111, 16'h2222, 1);
    drive("R10 opcode 14 no effect", 14, 1, 0, 16'h1111, 16'h2222, 1);
    drive("R10 opcode 15 no effect", 15, 0, 0, 16'h1111, 16'h2222, 1);
    drive("R9 clear step", 8, 0, 0, 0, 0, 1);
    drive("R9 clear dir", 12, 0, 0, 0, 0, 1);
    drive("R5 sign 8b", 5, 0, 0, 16'h0080, 16'h0000, 1);

    seed = 32'h1ACE;
    for (int i = 0; i < 40; i++) begin
      int o;
      seed = seed * 1103515245 + 12345;
      o = (seed >>> 16) % 14;
      if (o < 0) o = -o;
      drive("R2 R3 R8 mixed pattern", o, seed[3], seed[5],
            (seed >>> 7) & 16'hFFFF, (seed * 7 + 3) & 16'hFFFF, seed[9] | seed[10]);
    end

    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule